// File: doc/BRIEF.md
# Packed Complex Multiply and Butterfly Unit

This unit does complex arithmetic on 32-bit words that each hold one complex number. The real part sits in bits [31:16] and the imaginary part in bits [15:0]. Both parts are signed two's-complement 16-bit values. The unit owns two 32-bit result registers, `acc_hi` and `acc_lo`, which appear directly at its outputs. These registers act as the accumulator for multiply-accumulate and as the second operand of the butterfly.

A one-cycle `start` strobe launches an operation. The strobe carries an opcode and one or two source words. One clock later the new register contents are visible and `done` pulses high for one cycle.

There are four operations:
- Complex multiply into the registers.
- Complex multiply-accumulate onto the registers.
- Radix-2 butterfly that combines a source word with the register contents.
- Butterfly variant for Q15 FFT stages, which scales the register contents down by 15 bits before combining.

The surrounding pipeline handles decode and condition flags, so the unit has neither.

Top module: `cplx_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `acc_hi` and `acc_lo` read zero and `done` is low until the first `start`.
- R2: A `start` sampled at a rising edge makes `done` high for exactly the following cycle; with no `start`, `done` is low in the next cycle.
- R3: Opcode 2'b00 (complex multiply) writes `acc_hi = ar*br - ai*bi` and `acc_lo = ar*bi + ai*br`, where ar/ai are `src_a[31:16]`/`src_a[15:0]` and br/bi are `src_b[31:16]`/`src_b[15:0]`, all signed, with each result truncated to 32 bits.
- R4: Opcode 2'b01 (complex multiply-accumulate) adds the two R3 expressions to the current `acc_hi` and `acc_lo`, wrapping modulo 2^32.
- R5: Opcode 2'b10 (butterfly) sets `acc_hi[31:16] = ar + acc_hi[15:0]`, `acc_hi[15:0] = ai + acc_lo[15:0]`, `acc_lo[31:16] = ar - acc_hi[15:0]` and `acc_lo[15:0] = ai - acc_lo[15:0]`, with all four taken from register values before the update.
- R6: Opcode 2'b11 (scaled butterfly) does the same as R5 but uses the low 16 bits of `acc_hi >>> 15` and `acc_lo >>> 15`, where the shift is arithmetic, in place of the raw register values.
- R7: Every 16-bit butterfly field keeps the low 16 bits of its sum or difference, wrapping instead of saturating.
- R8: For opcodes 2'b10 and 2'b11 the value of `src_b` has no effect on the result.
- R9: Without `start`, `acc_hi` and `acc_lo` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 2 | Opcode: 00 multiply, 01 multiply-accumulate, 10 butterfly, 11 scaled butterfly |
| src_a | input | 32 | First packed complex operand |
| src_b | input | 32 | Second packed complex operand (multiply ops only) |
| acc_hi | output | 32 | High result register |
| acc_lo | output | 32 | Low result register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is a scaled butterfly whose shifted register values are large and of both signs. The registers have no direct load path, so they can only be written through the arithmetic itself. The stimulus first runs a complex multiply with a purely real second operand to place chosen values of about 2^28 in magnitude into the registers. It then applies the scaled butterfly to them, which exercises the arithmetic shift and the 16-bit wraparound. The same preload is repeated with different `src_b` values to show that the butterfly ignores that operand.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

    typedef enum logic [1:0] {
        OP_CMUL   = 2'b00,
        OP_CMAC   = 2'b01,
        OP_BFLY   = 2'b10,
        OP_BFLY_Q = 2'b11
    } cplx_op_e;

endpackage

// File: rtl/cplx_mul.sv
// Packed complex product: real part and imaginary part, each W bits wide.
module cplx_mul #(
    parameter int HW = 16,
    localparam int W = 2 * HW
) (
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    output logic [W-1:0] prod_re,
    output logic [W-1:0] prod_im
);
    logic signed [HW-1:0] a_re, a_im, b_re, b_im;
    logic signed [W-1:0]  p_rr, p_ii, p_ri, p_ir;

    always_comb begin
        a_re = mul_a[W-1:HW];
        a_im = mul_a[HW-1:0];
        b_re = mul_b[W-1:HW];
        b_im = mul_b[HW-1:0];
        p_rr = W'(a_re) * W'(b_re);
        p_ii = W'(a_im) * W'(b_im);
        p_ri = W'(a_re) * W'(b_im);
        p_ir = W'(a_im) * W'(b_re);
        prod_re = p_rr - p_ii;
        prod_im = p_ri + p_ir;
    end
endmodule

// File: rtl/cplx_bfly.sv
// Radix-2 butterfly of a packed source word against the two registers,
// after an arithmetic right shift of SHIFT bits on the register values.
module cplx_bfly #(
    parameter int HW    = 16,
    parameter int SHIFT = 0,
    localparam int W = 2 * HW
) (
    input  logic [W-1:0] bf_src,
    input  logic [W-1:0] reg_hi,
    input  logic [W-1:0] reg_lo,
    output logic [W-1:0] bf_hi,
    output logic [W-1:0] bf_lo
);
    logic [HW-1:0] term_re, term_im;
    logic [HW-1:0] src_re, src_im;

    always_comb begin
        term_re = HW'($signed(reg_hi) >>> SHIFT);
        term_im = HW'($signed(reg_lo) >>> SHIFT);
        src_re  = bf_src[W-1:HW];
        src_im  = bf_src[HW-1:0];
        bf_hi   = {src_re + term_re, src_im + term_im};
        bf_lo   = {src_re - term_re, src_im - term_im};
    end
endmodule

// File: rtl/cplx_unit.sv
module cplx_unit #(
    parameter int HW = 16,
    localparam int W    = 2 * HW,
    localparam int FRAC = HW - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic [W-1:0] acc_hi,
    output logic [W-1:0] acc_lo,
    output logic         done
);
    import cplx_pkg::*;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         done;
    } unit_state_t;

    unit_state_t st_d, st_q;
    cplx_op_e    op_e;
    logic [W-1:0] prod_re, prod_im;
    logic [W-1:0] bf_hi [2];
    logic [W-1:0] bf_lo [2];

    assign op_e = cplx_op_e'(op);

    cplx_mul #(.HW(HW)) u_mul (
        .mul_a  (src_a),
        .mul_b  (src_b),
        .prod_re(prod_re),
        .prod_im(prod_im)
    );

    // Variant 0: plain butterfly; variant 1: Q15-scaled butterfly.
    for (genvar g = 0; g < 2; g++) begin : g_bfly
        cplx_bfly #(.HW(HW), .SHIFT(g * FRAC)) u_bfly (
            .bf_src(src_a),
            .reg_hi(st_q.hi),
            .reg_lo(st_q.lo),
            .bf_hi (bf_hi[g]),
            .bf_lo (bf_lo[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            unique case (op_e)
                OP_CMUL: begin
                    st_d.hi = prod_re;
                    st_d.lo = prod_im;
                end
                OP_CMAC: begin
                    st_d.hi = st_q.hi + prod_re;
                    st_d.lo = st_q.lo + prod_im;
                end
                OP_BFLY: begin
                    st_d.hi = bf_hi[0];
                    st_d.lo = bf_lo[0];
                end
                OP_BFLY_Q: begin
                    st_d.hi = bf_hi[1];
                    st_d.lo = bf_lo[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hi = st_q.hi;
    assign acc_lo = st_q.lo;
    assign done   = st_q.done;
endmodule

// File: rtl/cplx_unit_chk.sv
module cplx_unit_chk #(
    parameter int HW = 16,
    localparam int W = 2 * HW
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic [W-1:0] acc_hi,
    input logic [W-1:0] acc_lo,
    input logic         done
);
    logic [HW-1:0] re_pair_sum, im_pair_sum;
    assign re_pair_sum = acc_hi[W-1:HW] + acc_lo[W-1:HW];
    assign im_pair_sum = acc_hi[HW-1:0] + acc_lo[HW-1:0];

    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_hi) && $stable(acc_lo)));

    p_cmul_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b00 && src_b == '0) |=> (acc_hi == '0 && acc_lo == '0));

    // Sum plus difference of a butterfly pair gives twice the source part (R5, R6, R7).
    p_bfly_re_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1]) |=> re_pair_sum == {$past(src_a[W-2:HW]), 1'b0});

    p_bfly_im_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1]) |=> im_pair_sum == {$past(src_a[HW-2:0]), 1'b0});
endmodule

bind cplx_unit cplx_unit_chk #(.HW(HW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .src_a (src_a),
    .src_b (src_b),
    .acc_hi(acc_hi),
    .acc_lo(acc_lo),
    .done  (done)
);

// File: tb/cplx_unit_test.sv
module cplx_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] saved_hi, saved_lo;

    cplx_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pk(int re, int im);
        return {16'(re), 16'(im)};
    endfunction

    // Reference model from the requirements.
    task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        int ar, ai, br, bi, re, im, th, tl;
        logic [15:0] h1, h0, l1, l0;
        ar = $signed(a[31:16]); ai = $signed(a[15:0]);
        br = $signed(b[31:16]); bi = $signed(b[15:0]);
        re = ar * br - ai * bi;
        im = ar * bi + ai * br;
        case (o)
            2'b00: begin m_hi = re; m_lo = im; end
            2'b01: begin m_hi = m_hi + re; m_lo = m_lo + im; end
            default: begin
                th = (o == 2'b11) ? ($signed(m_hi) >>> 15) : $signed(m_hi);
                tl = (o == 2'b11) ? ($signed(m_lo) >>> 15) : $signed(m_lo);
                h1 = 16'(ar + th); h0 = 16'(ai + tl);
                l1 = 16'(ar - th); l0 = 16'(ai - tl);
                m_hi = {h1, h0}; m_lo = {l1, l0};
            end
        endcase
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation, then check done and both registers one clock later.
    task automatic run_op(input string tag, input logic [1:0] o,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        model(o, a, b);
        @(negedge clk);
        start = 1'b0; src_b = 32'hDEAD_BEEF;
        check({tag, " done R2"}, {31'b0, done}, 32'd1);
        check({tag, " hi"}, acc_hi, m_hi);
        check({tag, " lo"}, acc_lo, m_lo);
        @(negedge clk);
        check({tag, " done drop R2"}, {31'b0, done}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 hi in reset", acc_hi, 32'd0);
        check("R1 lo in reset", acc_lo, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {31'b0, done}, 32'd0);
        check("R1 hi after reset", acc_hi, 32'd0);
    endtask

    task automatic t_cmul;
        run_op("R3 small", 2'b00, pk(3, 4), pk(5, -2));
        check("R3 literal re", acc_hi, 32'd23);
        check("R3 literal im", acc_lo, 32'd14);
        run_op("R3 wrap", 2'b00, pk(-32768, -32768), pk(-32768, -32768));
        check("R3 wrap literal im", acc_lo, 32'h8000_0000);
    endtask

    task automatic t_cmac;
        run_op("R4 seed", 2'b00, pk(100, -50), pk(7, 3));
        run_op("R4 acc1", 2'b01, pk(-1200, 333), pk(25, -9));
        run_op("R4 acc2", 2'b01, pk(32767, 32767), pk(32767, -32768));
    endtask

    task automatic t_bfly;
        run_op("R5 seed", 2'b00, pk(1234, -567), pk(1, 0));
        run_op("R5 bfly", 2'b10, pk(1000, 2000), pk(9, 9));
        run_op("R7 seed", 2'b00, pk(1, -2), pk(1, 0));
        run_op("R7 bfly wrap", 2'b10, pk(32767, -32768), 32'h0);
        check("R7 literal hi", acc_hi, {16'h8000, 16'h7FFE});
    endtask

    task automatic t_bfly_q;
        run_op("R6 seed", 2'b00, pk(16384, -16384), pk(16384, 0));
        run_op("R6 scaled", 2'b11, pk(100, 200), pk(3, 3));
        check("R6 literal hi", acc_hi, pk(8292, -7992));
        run_op("R6 seed odd", 2'b00, pk(-32768, 32767), pk(-12345, 0));
        run_op("R6 scaled odd", 2'b11, pk(-30000, 30000), 32'h1234_5678);
    endtask

    task automatic t_ignore_b;
        run_op("R8 seed a", 2'b00, pk(-777, 4321), pk(3, 0));
        run_op("R8 bfly b=0", 2'b10, pk(55, -66), 32'h0);
        saved_hi = acc_hi; saved_lo = acc_lo;
        run_op("R8 seed b", 2'b00, pk(-777, 4321), pk(3, 0));
        run_op("R8 bfly b=ff", 2'b10, pk(55, -66), 32'hFFFF_FFFF);
        check("R8 same hi", acc_hi, saved_hi);
        check("R8 same lo", acc_lo, saved_lo);
    endtask

    task automatic t_hold;
        run_op("R9 seed", 2'b00, pk(42, -42), pk(2, 1));
        @(negedge clk);
        op = 2'b01; src_a = pk(999, 999); src_b = pk(999, 999);
        repeat (4) @(negedge clk);
        check("R9 hi held", acc_hi, m_hi);
        check("R9 lo held", acc_lo, m_lo);
        check("R2 no start no done", {31'b0, done}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_cmul();
        t_cmac();
        t_bfly();
        t_bfly_q();
        t_ignore_b();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule